// File: doc/BRIEF.md
# Page Write-Lock Bit Manager

This block holds one lock bit per eight-byte page of a serial byte-addressed memory and runs the two-phase command that sets or clears those bits. It sits beside a two-wire serial protocol controller. The controller reports each START condition, each STOP condition and each received byte as single-cycle pulses. The block parses a fixed opening: START, a write command byte, a page-aligned address, a repeated START, a second write command byte and a control byte. After that it either streams lock bits back to the controller or enters a verification phase.

In the verification phase the master must send all eight bytes of the addressed page again, lowest address first. The block fetches each stored byte through a read port into the data memory and compares it with the incoming byte. It answers every byte with an ACK or a NACK. The lock bit changes at STOP only if all eight bytes matched and no ninth byte arrived. A successful change loads the highest address of the page into the controller's address counter and starts a busy window. During that window the block ignores all bus events. A lock bit of 1 means writes to the page are allowed. A lock bit of 0 means they are blocked. Other blocks read the bit for any page through a query port.

The sequencer states are: ST_IDLE, ST_S1 (START seen), ST_CMD1 (first write command taken), ST_ADDR (aligned page address taken), ST_S2 (repeated START seen), ST_CMD2 (second write command taken), ST_VERIFY (comparing page bytes), ST_ARMED (eight matches, waiting for STOP), ST_FAILED (mismatch or extra byte) and ST_READ (streaming lock bits).

The transitions are:
- START moves ST_ADDR to ST_S2 and moves every other state to ST_S1.
- STOP returns to ST_IDLE. From ST_ARMED it also commits the change.
- A byte in ST_S1 or ST_S2 advances only if it is a write command. A byte in ST_CMD1 advances only if it is a page-aligned address. A byte in ST_ADDR returns to ST_IDLE.
- In ST_CMD2 the control byte selects ST_READ, ST_VERIFY or ST_IDLE.
- In ST_VERIFY a match advances the byte index, and the eighth match enters ST_ARMED. A mismatch enters ST_FAILED. Any byte in ST_ARMED also enters ST_FAILED.
- While busy, the sequencer is held in ST_IDLE.

Top module: `pgprot_mgr`

## Requirements
- R1: After reset every page's lock bit is 1, so qry_wr_ok_o is 1 for every page. After reset busy_o, ack_vld_o, ptr_load_o and rd_mode_o are 0.
- R2: The block takes over only after this exact opening: START, a write command byte, an address byte, START, a write command byte, a control byte. A write command byte has bits [7:4] = 1010 and bit 0 = 0, and bits [3:1] are don't-care. The address byte's low three bits must be 000, and its upper bits give the page. Any deviation, including a read command (bit 0 = 1), a nonzero low address bit, or a byte in place of the repeated START, leaves later bytes unanswered (ack_vld_o stays 0).
- R3: Only bits [1:0] of the control byte are decoded. 00 selects lock-bit read, 01 locks the page (bit becomes 0), 11 unlocks it (bit becomes 1), and 10 does nothing. Bits [7:2] are ignored.
- R4: After a lock or unlock control byte, byte i (0 to 7) is compared with the stored byte at page base + i. mem_addr_o presents that address, and the memory answers one cycle later. One cycle after each byte, ack_vld_o pulses with ack_o = 1 on a match. After the first mismatch, that byte and every later byte of the command get ack_o = 0. A ninth byte also gets ack_o = 0.
- R5: STOP commits only after exactly eight matching bytes. In that case the lock bit takes its new value at that clock edge, and for one cycle ptr_load_o = 1 with ptr_addr_o = page base + 7. A STOP after fewer than eight bytes, after a mismatch or after a ninth byte changes no bit, raises no ptr_load_o and starts no busy window.
- R6: After a commit busy_o stays high for exactly BUSY_CYC cycles. While it is high, START, STOP and bytes are ignored: no ACK is given and the sequencer does not advance.
- R7: qry_wr_ok_o always equals the lock bit of page qry_page_i.
- R8: After a read control byte, rd_mode_o is 1 and tx_byte_o holds the addressed page's lock bit in bit 7 with bits [6:0] zero. Each mack_i pulse moves to the next page, and the last page wraps to page 0. STOP or START ends the read.
- R9: A START during any phase abandons it and restarts parsing of the opening. A new full command after that behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse: START or repeated START seen on the bus |
| stop_i | input | 1 | Pulse: STOP seen on the bus |
| rx_vld_i | input | 1 | Pulse: a byte from the master is complete |
| rx_byte_i | input | 8 | The received byte |
| ack_vld_o | output | 1 | Pulse: the block is answering the last byte |
| ack_o | output | 1 | 1 = ACK, 0 = NACK, valid with ack_vld_o |
| rd_mode_o | output | 1 | Block is sourcing read bytes |
| tx_byte_o | output | 8 | Byte to transmit in read mode |
| mack_i | input | 1 | Pulse: master acknowledged the transmitted byte |
| mem_addr_o | output | AW | Data memory read address |
| mem_rdata_i | input | 8 | Data memory read data, one cycle after the address |
| busy_o | output | 1 | Lock-bit update window in progress |
| ptr_load_o | output | 1 | Pulse: load ptr_addr_o into the address counter |
| ptr_addr_o | output | AW | Highest address of the updated page |
| qry_page_i | input | PW | Page index to query |
| qry_wr_ok_o | output | 1 | Lock bit of the queried page (1 = writable) |

## Verification
Verification bytes are driven in several forms: all eight correct, one byte corrupted at a random position, only seven bytes, and nine bytes. These cases separate an on-the-fly compare with sticky failure from a compare that only counts bytes or forgets an earlier mismatch. Control bytes carry random upper bits and every low-bit code, including the unused one, which shows that only two bits are decoded. Openings with a read command or a misaligned address show that ownership needs the exact sequence. Lock-bit reads start near the last page to expose wrap-around, and command traffic injected during the busy window shows that it is ignored.

// File: rtl/pgprot_pkg.sv
package pgprot_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S1,
        ST_CMD1,
        ST_ADDR,
        ST_S2,
        ST_CMD2,
        ST_VERIFY,
        ST_ARMED,
        ST_FAILED,
        ST_READ
    } seq_state_e;

    typedef enum logic [1:0] {
        CT_READ   = 2'b00,
        CT_LOCK   = 2'b01,
        CT_NONE   = 2'b10,
        CT_UNLOCK = 2'b11
    } ctrl_e;

    localparam logic [3:0] CMD_TAG = 4'b1010;

    function automatic logic is_wr_cmd(input logic [7:0] b);
        return (b[7:4] == CMD_TAG) && !b[0];
    endfunction

endpackage

// File: rtl/pgprot_bits.sv
module pgprot_bits #(
    parameter int NPAGES = 32,
    parameter int PW     = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [PW-1:0]     wr_page_i,
    input  logic              wr_val_i,
    input  logic [PW-1:0]     q_page_i,
    output logic              q_bit_o,
    input  logic [PW-1:0]     s_page_i,
    output logic              s_bit_o,
    output logic [NPAGES-1:0] bits_o
);

    logic [NPAGES-1:0] bits_q;

    for (genvar g = 0; g < NPAGES; g++) begin : g_bit
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                bits_q[g] <= 1'b1;
            end else if (wr_en_i && (wr_page_i == PW'(g))) begin
                bits_q[g] <= wr_val_i;
            end
        end
    end

    assign q_bit_o = bits_q[q_page_i];
    assign s_bit_o = bits_q[s_page_i];
    assign bits_o  = bits_q;

endmodule

// File: rtl/pgprot_timer.sv
module pgprot_timer #(
    parameter int CYC = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic go_i,
    output logic busy_o
);

    localparam int CW = (CYC > 2) ? $clog2(CYC) : 1;

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (go_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == CW'(CYC - 1)) begin
                busy_q <= 1'b0;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy_o = busy_q;

    // R6: a new update window never starts inside a running one
    a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_i |-> !busy_q);

endmodule

// File: rtl/pgprot_seq.sv
module pgprot_seq
    import pgprot_pkg::*;
#(
    parameter int PW         = 5,
    parameter int OFS_W      = 3,
    parameter int PAGE_BYTES = 8,
    parameter int NPAGES     = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  busy_i,
    input  logic                  start_i,
    input  logic                  stop_i,
    input  logic                  rx_vld_i,
    input  logic [7:0]            rx_byte_i,
    input  logic [7:0]            mem_rdata_i,
    input  logic                  mack_i,
    output logic                  ack_vld_o,
    output logic                  ack_o,
    output logic                  rd_mode_o,
    output logic [PW-1:0]         rd_page_o,
    output logic [PW+OFS_W-1:0]   mem_addr_o,
    output logic                  commit_o,
    output logic                  commit_val_o,
    output logic [PW-1:0]         page_o,
    output logic                  ptr_load_o,
    output logic [PW+OFS_W-1:0]   ptr_addr_o
);

    seq_state_e           state_q, state_d;
    logic [PW-1:0]        page_q, rd_page_q;
    logic [OFS_W-1:0]     idx_q;
    logic                 val_q;
    logic                 ack_vld_q, ack_q, ptr_load_q;
    logic [PW+OFS_W-1:0]  ptr_addr_q;

    logic quiet, rx_ev, match, last;
    assign quiet = !busy_i && !start_i && !stop_i;
    assign rx_ev = quiet && rx_vld_i;
    assign match = (rx_byte_i == mem_rdata_i);
    assign last  = (idx_q == OFS_W'(PAGE_BYTES - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (busy_i) begin
            state_d = ST_IDLE;
        end else if (start_i) begin
            state_d = (state_q == ST_ADDR) ? ST_S2 : ST_S1;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else if (rx_vld_i) begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_S1:     state_d = is_wr_cmd(rx_byte_i) ? ST_CMD1 : ST_IDLE;
                ST_CMD1:   state_d = (rx_byte_i[OFS_W-1:0] == '0) ? ST_ADDR : ST_IDLE;
                ST_ADDR:   state_d = ST_IDLE;
                ST_S2:     state_d = is_wr_cmd(rx_byte_i) ? ST_CMD2 : ST_IDLE;
                ST_CMD2: begin
                    unique case (ctrl_e'(rx_byte_i[1:0]))
                        CT_READ:   state_d = ST_READ;
                        CT_LOCK:   state_d = ST_VERIFY;
                        CT_UNLOCK: state_d = ST_VERIFY;
                        CT_NONE:   state_d = ST_IDLE;
                        default:   state_d = ST_IDLE;
                    endcase
                end
                ST_VERIFY: state_d = !match ? ST_FAILED : (last ? ST_ARMED : ST_VERIFY);
                ST_ARMED:  state_d = ST_FAILED;
                ST_FAILED: state_d = ST_FAILED;
                ST_READ:   state_d = ST_READ;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers: page, byte index, lock value, read pointer
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            page_q    <= '0;
            idx_q     <= '0;
            val_q     <= 1'b1;
            rd_page_q <= '0;
        end else begin
            if (rx_ev && state_q == ST_CMD1) begin
                page_q <= rx_byte_i[PW+OFS_W-1:OFS_W];
            end
            if (rx_ev && state_q == ST_CMD2) begin
                idx_q     <= '0;
                val_q     <= rx_byte_i[1];
                rd_page_q <= page_q;
            end else if (rx_ev && state_q == ST_VERIFY && match && !last) begin
                idx_q <= idx_q + 1'b1;
            end
            if (quiet && mack_i && state_q == ST_READ) begin
                rd_page_q <= (rd_page_q == PW'(NPAGES - 1)) ? '0 : rd_page_q + 1'b1;
            end
        end
    end

    // output registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ack_vld_q  <= 1'b0;
            ack_q      <= 1'b0;
            ptr_load_q <= 1'b0;
            ptr_addr_q <= '0;
        end else begin
            ack_vld_q  <= rx_ev && (state_q == ST_VERIFY || state_q == ST_ARMED ||
                                    state_q == ST_FAILED);
            ack_q      <= rx_ev && state_q == ST_VERIFY && match;
            ptr_load_q <= commit_o;
            if (commit_o) begin
                ptr_addr_q <= {page_q, {OFS_W{1'b1}}};
            end
        end
    end

    assign commit_o     = !busy_i && stop_i && state_q == ST_ARMED;
    assign commit_val_o = val_q;
    assign page_o       = page_q;
    assign mem_addr_o   = {page_q, idx_q};
    assign rd_mode_o    = (state_q == ST_READ);
    assign rd_page_o    = rd_page_q;
    assign ack_vld_o    = ack_vld_q;
    assign ack_o        = ack_q;
    assign ptr_load_o   = ptr_load_q;
    assign ptr_addr_o   = ptr_addr_q;

    // R8: each master ACK in read mode moves to the next page with wrap
    a_r8_page_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_READ && mack_i && quiet) |=>
        (rd_page_q == (($past(rd_page_q) == PW'(NPAGES - 1)) ? '0 : $past(rd_page_q) + 1'b1)));

    // R5: a commit only ever follows a STOP seen in the armed state
    a_r5_commit_needs_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_o |-> (stop_i && $past(state_d) == ST_ARMED));

endmodule

// File: rtl/pgprot_mgr.sv
module pgprot_mgr
    import pgprot_pkg::*;
#(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 8,
    parameter int BUSY_CYC   = 32,
    localparam int AW        = $clog2(MEM_BYTES),
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int PW        = AW - OFS_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          rx_vld_i,
    input  logic [7:0]    rx_byte_i,
    output logic          ack_vld_o,
    output logic          ack_o,
    output logic          rd_mode_o,
    output logic [7:0]    tx_byte_o,
    input  logic          mack_i,
    output logic [AW-1:0] mem_addr_o,
    input  logic [7:0]    mem_rdata_i,
    output logic          busy_o,
    output logic          ptr_load_o,
    output logic [AW-1:0] ptr_addr_o,
    input  logic [PW-1:0] qry_page_i,
    output logic          qry_wr_ok_o
);

    localparam int NPAGES = MEM_BYTES / PAGE_BYTES;

    logic              commit, commit_val, s_bit;
    logic [PW-1:0]     page, rd_page;
    logic [NPAGES-1:0] bits;

    pgprot_timer #(.CYC(BUSY_CYC)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (commit),
        .busy_o (busy_o)
    );

    pgprot_seq #(
        .PW(PW), .OFS_W(OFS_W), .PAGE_BYTES(PAGE_BYTES), .NPAGES(NPAGES)
    ) u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .busy_i       (busy_o),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .rx_vld_i     (rx_vld_i),
        .rx_byte_i    (rx_byte_i),
        .mem_rdata_i  (mem_rdata_i),
        .mack_i       (mack_i),
        .ack_vld_o    (ack_vld_o),
        .ack_o        (ack_o),
        .rd_mode_o    (rd_mode_o),
        .rd_page_o    (rd_page),
        .mem_addr_o   (mem_addr_o),
        .commit_o     (commit),
        .commit_val_o (commit_val),
        .page_o       (page),
        .ptr_load_o   (ptr_load_o),
        .ptr_addr_o   (ptr_addr_o)
    );

    pgprot_bits #(.NPAGES(NPAGES), .PW(PW)) u_bits (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (commit),
        .wr_page_i (page),
        .wr_val_i  (commit_val),
        .q_page_i  (qry_page_i),
        .q_bit_o   (qry_wr_ok_o),
        .s_page_i  (rd_page),
        .s_bit_o   (s_bit),
        .bits_o    (bits)
    );

    assign tx_byte_o = {s_bit, 7'b0};

    // R4: an answer only follows a received byte
    a_r4_ack_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_vld_o |-> $past(rx_vld_i));

    // R5: lock bits change only on the edge that saw STOP
    a_r5_bits_at_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(bits) |-> $past(stop_i));

    // R5: every update window opens together with the pointer load
    a_r5_busy_with_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> ptr_load_o);

    // R6: nothing is answered or sourced while busy
    a_r6_quiet_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (!ack_vld_o && !rd_mode_o));

endmodule

// File: tb/pgprot_mgr_tb_top.sv
module pgprot_mgr_tb_top;

    localparam int MEMB = 256;
    localparam int NP   = 32;
    localparam int BC   = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0, rx_vld_i = 1'b0, mack_i = 1'b0;
    logic [7:0] rx_byte_i = '0;
    logic       ack_vld_o, ack_o, rd_mode_o, busy_o, ptr_load_o, qry_wr_ok_o;
    logic [7:0] tx_byte_o, mem_rdata;
    logic [7:0] mem_addr_o, ptr_addr_o;
    logic [4:0] qry_page = '0;

    logic [7:0] mem [MEMB];
    logic       exp_bit [NP];
    int         n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) mem_rdata <= mem[mem_addr_o];

    pgprot_mgr #(.MEM_BYTES(MEMB), .PAGE_BYTES(8), .BUSY_CYC(BC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .stop_i(stop_i),
        .rx_vld_i(rx_vld_i), .rx_byte_i(rx_byte_i), .ack_vld_o(ack_vld_o),
        .ack_o(ack_o), .rd_mode_o(rd_mode_o), .tx_byte_o(tx_byte_o),
        .mack_i(mack_i), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata),
        .busy_o(busy_o), .ptr_load_o(ptr_load_o), .ptr_addr_o(ptr_addr_o),
        .qry_page_i(qry_page), .qry_wr_ok_o(qry_wr_ok_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wr_cmd();
        return 8'hA0 | 8'(($urandom % 8) << 1);
    endfunction

    task automatic bus_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic av, output logic a);
        @(negedge clk); rx_vld_i = 1'b1; rx_byte_i = b;
        @(negedge clk); rx_vld_i = 1'b0; av = ack_vld_o; a = ack_o;
        @(negedge clk);
    endtask

    // stop, then check the commit response; optionally wait out the busy window
    task automatic bus_stop(input bit exp_commit, input int pg, input bit wait_busy);
        int cnt = 0;
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        chk(ptr_load_o == exp_commit, "R5 ptr_load", ptr_load_o, exp_commit);
        chk(busy_o == exp_commit, "R5 busy start", busy_o, exp_commit);
        if (exp_commit)
            chk(ptr_addr_o == 8'(pg * 8 + 7), "R5 ptr_addr", ptr_addr_o, pg * 8 + 7);
        if (wait_busy && exp_commit) begin
            while (busy_o && cnt < 1000) begin
                cnt++;
                @(negedge clk);
            end
            chk(cnt == BC, "R6 busy length", cnt, BC);
        end
    endtask

    task automatic check_bits(input string req);
        for (int p = 0; p < NP; p++) begin
            qry_page = 5'(p);
            #1;
            chk(qry_wr_ok_o == exp_bit[p], req, qry_wr_ok_o, exp_bit[p]);
        end
    endtask

    // full lock/unlock command; bad<8 corrupts that byte, good_seq=0 misaligns the address
    task automatic do_cmd(input int pg, input logic [7:0] ctrl, input int nb,
                          input int bad, input bit good_seq, input bit send_stop,
                          input bit wait_busy);
        logic av, a;
        bit owned, ok;
        logic [7:0] d;
        owned = good_seq && (ctrl[1:0] == 2'b01 || ctrl[1:0] == 2'b11);
        ok = 1'b1;
        bus_start();
        send_byte(wr_cmd(), av, a);
        chk(av == 1'b0, "R2 cmd not answered", av, 0);
        send_byte(8'(pg * 8) | (good_seq ? 8'h0 : 8'h5), av, a);
        bus_start();
        send_byte(wr_cmd(), av, a);
        send_byte(ctrl, av, a);
        for (int i = 0; i < nb; i++) begin
            d = (i < 8) ? mem[pg * 8 + i] : 8'($urandom);
            if (i == bad) d = d ^ 8'(1 << ($urandom % 8));
            if (i == bad || i >= 8) ok = 1'b0;
            send_byte(d, av, a);
            chk(av == owned, owned ? "R4 ack valid" : "R2 not owned", av, owned);
            if (owned) chk(a == ok, "R4 ack value", a, ok);
        end
        if (send_stop) begin
            bus_stop(owned && ok && nb == 8, pg, wait_busy);
            if (owned && ok && nb == 8) exp_bit[pg] = ctrl[1];
        end
    endtask

    task automatic do_read(input int pg, input int n);
        logic av, a;
        int cur = pg;
        bus_start();
        send_byte(wr_cmd(), av, a);
        send_byte(8'(pg * 8), av, a);
        bus_start();
        send_byte(wr_cmd(), av, a);
        send_byte({6'($urandom), 2'b00}, av, a);
        chk(rd_mode_o == 1'b1, "R8 read mode", rd_mode_o, 1);
        for (int k = 0; k < n; k++) begin
            chk(tx_byte_o == {exp_bit[cur], 7'b0}, "R8 tx byte", tx_byte_o, {exp_bit[cur], 7'b0});
            @(negedge clk); mack_i = 1'b1;
            @(negedge clk); mack_i = 1'b0;
            cur = (cur + 1) % NP;
        end
        bus_stop(1'b0, pg, 1'b0);
        chk(rd_mode_o == 1'b0, "R8 read ends", rd_mode_o, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        logic av, a;
        void'($urandom(32'h5eed));
        for (int i = 0; i < MEMB; i++) mem[i] = 8'($urandom);
        for (int p = 0; p < NP; p++) exp_bit[p] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy_o == 0 && ack_vld_o == 0 && ptr_load_o == 0 && rd_mode_o == 0,
            "R1 reset outputs", {busy_o, ack_vld_o, ptr_load_o, rd_mode_o}, 0);
        check_bits("R1 reset bits");

        // R4 R5 R6 R7 lock page 0 and last page, unlock page 0
        do_cmd(0, 8'h01, 8, 99, 1, 1, 1);
        do_cmd(NP - 1, 8'hFD, 8, 99, 1, 1, 1);
        check_bits("R7 after lock");
        do_cmd(0, 8'h03, 8, 99, 1, 1, 1);
        check_bits("R7 after unlock");

        // R8 read with wrap from near the last page
        do_read(NP - 2, 4);

        // R4 R5 mismatch, short, long
        do_cmd(5, 8'h01, 8, 0, 1, 1, 1);
        do_cmd(6, 8'h01, 8, 7, 1, 1, 1);
        do_cmd(7, 8'h01, 7, 99, 1, 1, 1);
        do_cmd(8, 8'h01, 9, 99, 1, 1, 1);
        check_bits("R5 no commit");

        // R3 unused control code; R2 misaligned address and read command opening
        do_cmd(9, 8'h56, 8, 99, 1, 1, 1);
        do_cmd(10, 8'h01, 8, 99, 0, 1, 1);
        bus_start();
        send_byte(8'hA1, av, a);
        send_byte(8'h50, av, a);
        bus_start();
        send_byte(8'hA0, av, a);
        send_byte(8'h01, av, a);
        send_byte(mem[8'h50], av, a);
        chk(av == 1'b0, "R2 read command opening", av, 0);
        bus_stop(1'b0, 10, 1'b0);
        check_bits("R3 R2 no change");

        // R6 activity during busy is ignored
        do_cmd(11, 8'h01, 8, 99, 1, 1, 0);
        bus_start();
        send_byte(8'hA0, av, a);
        send_byte(8'h60, av, a);
        bus_start();
        send_byte(8'hA0, av, a);
        send_byte(8'h01, av, a);
        send_byte(mem[8'h60], av, a);
        chk(av == 1'b0 && busy_o == 1'b1, "R6 ignored while busy", {av, busy_o}, 1);
        while (busy_o) @(negedge clk);
        send_byte(mem[8'h61], av, a);
        chk(av == 1'b0, "R6 no progress after busy", av, 0);
        check_bits("R6 bits");

        // R9 START mid-verify, then a full command
        do_cmd(12, 8'h01, 3, 99, 1, 0, 0);
        do_cmd(12, 8'h01, 8, 99, 1, 1, 1);
        check_bits("R9 restart");

        // random mix
        for (int it = 0; it < 30; it++) begin
            int pg, nb, bad;
            logic [7:0] c;
            pg  = $urandom % NP;
            nb  = 7 + ($urandom % 3);
            bad = ($urandom % 3 == 0) ? ($urandom % 8) : 99;
            c   = {6'($urandom), 2'($urandom)};
            if (c[1:0] == 2'b00) c[0] = 1'b1;
            do_cmd(pg, c, nb, bad, 1, 1, 1);
        end
        check_bits("R7 random");
        do_read($urandom % NP, 6);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule